// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Style and Level Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words enter on the write clock while write-enable is high and the buffer has room. They leave on the read clock in the order they were written. Each pointer crosses to the other clock domain as a Gray code through a chain of synchronizing flops. Every status flag is therefore computed from registered state and never from a raw pointer of the other domain.

The read style is fixed at reset by the `mode_sel` input. In standard style, each word, including the first, must be requested with `ren`. The two primary flags then report "not empty" and "not full". In fall-through style, an output register holds the oldest word at `dout` without any request, and `ren` consumes it. The primary flags then report "no valid output" and "no room". That output register adds one word of capacity, so every level threshold in fall-through style sits one word higher.

Three level flags are active low and are available in both styles: almost-empty, half-full and almost-full. The almost-empty offset n and the almost-full offset m are registers. They take the value 2 unless a parallel value is presented with `ofs_load` while reset is held.

Top module: `dcfifo_dual_mode`

## Requirements
- R1: After reset, with nothing stored, the flags read as follows. In standard style `ef_or`=0 and `full_ir`=1. In fall-through style `ef_or`=1 and `full_ir`=0. In both styles `ae_n`=0, `hf_n`=1 and `af_n`=1.
- R2: The read style is the level of `mode_sel` sampled while `rst` is high: 0 selects standard style and 1 selects fall-through style. Changing `mode_sel` after reset has no effect until the next reset.
- R3: In standard style, `dout` changes only on a read-clock edge where `ren`=1 and data is present. Words come out in write order.
- R4: In fall-through style, the first word written into an empty buffer appears at `dout` with `ef_or`=0 on the third read-clock rising edge after the write edge, with no `ren`. A read-clock edge with `ren`=1 replaces it with the next word, and words come out in write order.
- R5: In standard style, `ef_or` is 1 whenever at least one word is stored. It rises on the second read-clock edge after the first write. `full_ir` goes to 0 once D words are stored.
- R6: In fall-through style, `full_ir` goes to 1 only after D+1 words are stored, counting the word in the output register.
- R7: Let n be the empty offset and k the number of stored words. `ae_n` is 0 when k ≤ n in standard style, and when k ≤ n+1 in fall-through style.
- R8: `hf_n` is 0 when k ≥ D/2+1 in standard style, and when k ≥ D/2+2 in fall-through style.
- R9: Let m be the full offset. `af_n` is 0 when k ≥ D−m in standard style, and when k ≥ D+1−m in fall-through style.
- R10: `ren` has no effect while the buffer is empty: `dout` holds its value and no word is lost or skipped.
- R11: `wen` has no effect while the buffer is full, and the attempted word is never read out. The first read from a full buffer releases the full indication on `full_ir`.
- R12: Both offsets reset to 2. If `ofs_load`=1 during reset, they take `ofs_empty` and `ofs_full` instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| mode_sel | input | 1 | Read style sampled at reset: 0 standard, 1 fall-through |
| ofs_load | input | 1 | During reset, take offsets from the two ports below |
| ofs_empty | input | $clog2(DEPTH)+1 | Empty offset n to load |
| ofs_full | input | $clog2(DEPTH)+1 | Full offset m to load |
| wen | input | 1 | Write enable (write clock domain) |
| din | input | WIDTH | Write data |
| ren | input | 1 | Read enable (read clock domain) |
| dout | output | WIDTH | Read data |
| ef_or | output | 1 | Standard style: 1 = data present. Fall-through style: 1 = no valid output word |
| full_ir | output | 1 | Standard style: 0 = full. Fall-through style: 1 = full |
| ae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low |
| af_n | output | 1 | Almost-full, active low |

## Verification
A table of fill levels is used in both read styles. Each entry fills the buffer to one level without reading, checks all five flags, then drains the buffer and compares every word. The levels are chosen on both sides of each threshold, so an off-by-one in a threshold, or a missing one-word shift in fall-through style, shows up as a flag difference at a single entry. Directed cases cover the rest:
- the exact edge on which the first word falls through;
- reads while empty and writes while full, using a marker word that must never come out;
- a style change after reset;
- loaded offsets moved away from the defaults.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    localparam int OFS_DEFAULT = 2;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 18,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          mode_sel,
    input  logic          ofs_load,
    input  logic [PW-1:0] ofs_full,
    input  logic          wen,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-2:0] waddr,
    output logic          wr_fire,
    output logic [PW-1:0] wgray,
    output logic          full_ir,
    output logic          hf_n,
    output logic          af_n
);
    localparam logic [PW-1:0] DEF_OFS = PW'(OFS_DEFAULT);
    localparam logic [PW-1:0] CAP     = PW'(DEPTH);
    localparam logic [PW-1:0] HF_LIM  = PW'(DEPTH / 2 + 1);

    rd_mode_e      mode_q;
    logic [PW-1:0] m_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic [PW:0]   af_lim;
    logic          full;

    always_comb begin
        rbin_s   = PW'(gray2bin(32'(rgray_s)));
        used     = wbin - rbin_s;
        full     = (used == CAP);
        wr_fire  = wen && !full;
        wbin_nxt = wbin + PW'(1);
        af_lim   = (PW+1)'(DEPTH) - {1'b0, m_q};
    end

    always_ff @(posedge wclk) begin
        if (rst) begin
            mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
            m_q    <= ofs_load ? ofs_full : DEF_OFS;
            wbin   <= '0;
            wgray  <= '0;
        end else if (wr_fire) begin
            wbin   <= wbin_nxt;
            wgray  <= PW'(bin2gray(32'(wbin_nxt)));
        end
    end

    assign waddr   = wbin[PW-2:0];
    assign full_ir = (mode_q == MODE_STD) ? !full : full;
    assign hf_n    = !(used >= HF_LIM);
    assign af_n    = !({1'b0, used} >= af_lim);

    AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R5
    AST_WR_OCC_BOUND: assert property (@(posedge wclk) disable iff (rst)
        used <= CAP); // R11
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
        (full && wen) |=> $stable(wgray)); // R11
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 18,
    parameter int PW    = 5
) (
    input  logic             rclk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic             ofs_load,
    input  logic [PW-1:0]    ofs_empty,
    input  logic             ren,
    input  logic [PW-1:0]    wgray_s,
    input  logic [WIDTH-1:0] rdata,
    output logic [PW-2:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [WIDTH-1:0] dout,
    output logic             ef_or,
    output logic             ae_n
);
    localparam logic [PW-1:0] DEF_OFS = PW'(OFS_DEFAULT);
    localparam logic [PW-1:0] CAP     = PW'(DEPTH);

    rd_mode_e      mode_q;
    logic [PW-1:0] n_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] mem_used;
    logic          mem_empty;
    logic          ovalid;
    logic          load;

    always_comb begin
        wbin_s    = PW'(gray2bin(32'(wgray_s)));
        mem_used  = wbin_s - rbin;
        mem_empty = (mem_used == '0);
        rbin_nxt  = rbin + PW'(1);
        if (mode_q == MODE_STD) begin
            load = ren && !mem_empty;
        end else begin
            load = !mem_empty && (!ovalid || ren);
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
            n_q    <= ofs_load ? ofs_empty : DEF_OFS;
            rbin   <= '0;
            rgray  <= '0;
            dout   <= '0;
            ovalid <= 1'b0;
        end else begin
            if (load) begin
                rbin  <= rbin_nxt;
                rgray <= PW'(bin2gray(32'(rbin_nxt)));
                dout  <= rdata;
            end
            if (mode_q == MODE_FWFT) begin
                if (load) begin
                    ovalid <= 1'b1;
                end else if (ren) begin
                    ovalid <= 1'b0;
                end
            end
        end
    end

    assign raddr = rbin[PW-2:0];
    assign ef_or = (mode_q == MODE_STD) ? !mem_empty : !ovalid;
    assign ae_n  = (mem_used > n_q);

    AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1); // R5
    AST_RD_OCC_BOUND: assert property (@(posedge rclk) disable iff (rst)
        mem_used <= CAP); // R5
    AST_EMPTY_HOLDS_DOUT: assert property (@(posedge rclk) disable iff (rst)
        mem_empty |=> $stable(dout)); // R10
    AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (rst)
        (mode_q == MODE_FWFT && ovalid && !ren) |=> (ovalid && $stable(dout))); // R4
endmodule

// File: rtl/dcfifo_dual_mode.sv
`timescale 1ns/1ps
module dcfifo_dual_mode #(
    parameter int DEPTH       = 16,
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2,
    localparam int PW         = $clog2(DEPTH) + 1
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic             ofs_load,
    input  logic [PW-1:0]    ofs_empty,
    input  logic [PW-1:0]    ofs_full,
    input  logic             wen,
    input  logic [WIDTH-1:0] din,
    input  logic             ren,
    output logic [WIDTH-1:0] dout,
    output logic             ef_or,
    output logic             full_ir,
    output logic             ae_n,
    output logic             hf_n,
    output logic             af_n
);
    logic [PW-2:0]    waddr;
    logic [PW-2:0]    raddr;
    logic             wr_fire;
    logic [PW-1:0]    wgray;
    logic [PW-1:0]    rgray;
    logic [PW-1:0]    wgray_s;
    logic [PW-1:0]    rgray_s;
    logic [WIDTH-1:0] rdata;

    dcfifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .wclk (wclk),
        .we   (wr_fire),
        .waddr(waddr),
        .wdata(din),
        .raddr(raddr),
        .rdata(rdata)
    );

    dcfifo_sync #(.N(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk),
        .rst(rst),
        .d  (wgray),
        .q  (wgray_s)
    );

    dcfifo_sync #(.N(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk),
        .rst(rst),
        .d  (rgray),
        .q  (rgray_s)
    );

    dcfifo_wr_ctl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .wclk    (wclk),
        .rst     (rst),
        .mode_sel(mode_sel),
        .ofs_load(ofs_load),
        .ofs_full(ofs_full),
        .wen     (wen),
        .rgray_s (rgray_s),
        .waddr   (waddr),
        .wr_fire (wr_fire),
        .wgray   (wgray),
        .full_ir (full_ir),
        .hf_n    (hf_n),
        .af_n    (af_n)
    );

    dcfifo_rd_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_rd (
        .rclk     (rclk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .ofs_load (ofs_load),
        .ofs_empty(ofs_empty),
        .ren      (ren),
        .wgray_s  (wgray_s),
        .rdata    (rdata),
        .raddr    (raddr),
        .rgray    (rgray),
        .dout     (dout),
        .ef_or    (ef_or),
        .ae_n     (ae_n)
    );
endmodule

// File: tb/dcfifo_dual_mode_bench.sv
`timescale 1ns/1ps
module dcfifo_dual_mode_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int D           = 16;
    localparam int NVEC        = 17;

    // {mode, writes, {ef_or, full_ir, ae_n, hf_n, af_n}} with n = m = 2
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 5'd0,  5'b01011},
        {1'b0, 5'd2,  5'b11011},
        {1'b0, 5'd3,  5'b11111},
        {1'b0, 5'd8,  5'b11111},
        {1'b0, 5'd9,  5'b11101},
        {1'b0, 5'd13, 5'b11101},
        {1'b0, 5'd14, 5'b11100},
        {1'b0, 5'd16, 5'b10100},
        {1'b1, 5'd0,  5'b10011},
        {1'b1, 5'd1,  5'b00011},
        {1'b1, 5'd3,  5'b00011},
        {1'b1, 5'd4,  5'b00111},
        {1'b1, 5'd9,  5'b00111},
        {1'b1, 5'd10, 5'b00101},
        {1'b1, 5'd14, 5'b00101},
        {1'b1, 5'd15, 5'b00100},
        {1'b1, 5'd17, 5'b01100}
    };

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_sel = 1'b0;
    logic        ofs_load = 1'b0;
    logic [4:0]  ofs_empty = '0;
    logic [4:0]  ofs_full = '0;
    logic        wen = 1'b0;
    logic [17:0] din = '0;
    logic        ren = 1'b0;
    logic [17:0] dout;
    logic        ef_or, full_ir, ae_n, hf_n, af_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic cur_mode = 1'b0;

    dcfifo_dual_mode u_dcfifo_dual_mode (
        .wclk(wclk), .rclk(rclk), .rst(rst), .mode_sel(mode_sel),
        .ofs_load(ofs_load), .ofs_empty(ofs_empty), .ofs_full(ofs_full),
        .wen(wen), .din(din), .ren(ren), .dout(dout),
        .ef_or(ef_or), .full_ir(full_ir), .ae_n(ae_n), .hf_n(hf_n), .af_n(af_n)
    );

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    function automatic logic [17:0] pat(int v, int i);
        return 18'((v << 10) ^ (i * 37) ^ 18'h05A5A);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic mode, logic load, logic [4:0] n, logic [4:0] m);
        @(negedge wclk);
        rst = 1'b1; mode_sel = mode; ofs_load = load; ofs_empty = n; ofs_full = m;
        wen = 1'b0; ren = 1'b0;
        repeat (4) @(negedge rclk);
        repeat (2) @(negedge wclk);
        rst = 1'b0; ofs_load = 1'b0;
        cur_mode = mode;
        repeat (2) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic write_word(logic [17:0] d);
        @(negedge wclk);
        wen = 1'b1; din = d;
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic read_word(output logic [17:0] d);
        @(negedge rclk);
        if (cur_mode) begin
            d = dout;
            ren = 1'b1;
            @(negedge rclk);
            ren = 1'b0;
        end else begin
            ren = 1'b1;
            @(negedge rclk);
            ren = 1'b0;
            d = dout;
        end
    endtask

    function automatic logic [4:0] flags();
        return {ef_or, full_ir, ae_n, hf_n, af_n};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [17:0] got;

        // R1: reset state, both styles, before any settling
        do_reset(1'b0, 1'b0, 5'd0, 5'd0);
        check("R1 std reset flags", 32'(flags()), 32'(5'b01011));
        do_reset(1'b1, 1'b0, 5'd0, 5'd0);
        check("R1 fwft reset flags", 32'(flags()), 32'(5'b10011));

        // Table walk: fill levels around every threshold, then drain
        for (int v = 0; v < NVEC; v++) begin
            logic       vm;
            int         k;
            vm = VEC[v][10];
            k  = int'(VEC[v][9:5]);
            do_reset(vm, 1'b0, 5'd0, 5'd0);
            for (int i = 0; i < k; i++) write_word(pat(v, i));
            settle();
            check("R5 R6 R7 R8 R9 level flags", 32'(flags()), 32'(VEC[v][4:0]));
            for (int i = 0; i < k; i++) begin
                read_word(got);
                check(vm ? "R4 fall-through order" : "R3 standard order", 32'(got), 32'(pat(v, i)));
            end
            settle();
            check("R5 empty after drain", 32'(ef_or), 32'(vm));
        end

        // R4: exact fall-through latency; R5: standard empty flag latency
        do_reset(1'b1, 1'b0, 5'd0, 5'd0);
        @(negedge wclk); wen = 1'b1; din = 18'h1234;
        @(posedge wclk); #1 wen = 1'b0;
        repeat (2) @(posedge rclk);
        #1 check("R4 not valid after two read edges", 32'(ef_or), 32'd1);
        @(posedge rclk);
        #1 check("R4 valid on third read edge", 32'(ef_or), 32'd0);
        check("R4 fall-through data", 32'(dout), 32'h1234);

        do_reset(1'b0, 1'b0, 5'd0, 5'd0);
        @(negedge wclk); wen = 1'b1; din = 18'h0777;
        @(posedge wclk); #1 wen = 1'b0;
        @(posedge rclk);
        #1 check("R5 empty still low after one read edge", 32'(ef_or), 32'd0);
        @(posedge rclk);
        #1 check("R5 empty flag high on second read edge", 32'(ef_or), 32'd1);
        check("R3 no read without ren", 32'(dout), 32'd0);

        // R2: style is latched at reset
        do_reset(1'b0, 1'b0, 5'd0, 5'd0);
        mode_sel = 1'b1;
        write_word(18'h0ABC);
        settle();
        check("R2 standard kept: data flag", 32'(ef_or), 32'd1);
        check("R2 standard kept: no fall-through", 32'(dout), 32'd0);
        do_reset(1'b1, 1'b0, 5'd0, 5'd0);
        mode_sel = 1'b0;
        write_word(18'h0DEF);
        settle();
        check("R2 fall-through kept: valid", 32'(ef_or), 32'd0);
        check("R2 fall-through kept: data", 32'(dout), 32'h0DEF);

        // R10: reads while empty are ignored
        do_reset(1'b0, 1'b0, 5'd0, 5'd0);
        write_word(18'h00A1);
        settle();
        read_word(got);
        check("R10 first word", 32'(got), 32'h00A1);
        settle();
        for (int i = 0; i < 3; i++) begin
            @(negedge rclk); ren = 1'b1;
            @(negedge rclk); ren = 1'b0;
        end
        check("R10 dout held while empty", 32'(dout), 32'h00A1);
        check("R10 still empty", 32'(ef_or), 32'd0);
        write_word(18'h00B2);
        settle();
        read_word(got);
        check("R10 next word not skipped", 32'(got), 32'h00B2);

        // R11: writes while full are ignored, first read releases full (standard)
        do_reset(1'b0, 1'b0, 5'd0, 5'd0);
        for (int i = 0; i < D; i++) write_word(pat(40, i));
        write_word(18'h3FFFF);
        settle();
        check("R11 std full", 32'(full_ir), 32'd0);
        read_word(got);
        check("R11 std first out", 32'(got), 32'(pat(40, 0)));
        settle();
        check("R11 std full released", 32'(full_ir), 32'd1);
        for (int i = 1; i < D; i++) begin
            read_word(got);
            check("R11 std contents", 32'(got), 32'(pat(40, i)));
        end
        settle();
        check("R11 std marker not stored", 32'(ef_or), 32'd0);

        // R11 and R6 in fall-through style
        do_reset(1'b1, 1'b0, 5'd0, 5'd0);
        for (int i = 0; i < D + 1; i++) write_word(pat(41, i));
        write_word(18'h3FFFF);
        settle();
        check("R6 fwft full at D+1", 32'(full_ir), 32'd1);
        read_word(got);
        check("R11 fwft first out", 32'(got), 32'(pat(41, 0)));
        settle();
        check("R11 fwft full released", 32'(full_ir), 32'd0);
        for (int i = 1; i < D + 1; i++) begin
            read_word(got);
            check("R11 fwft contents", 32'(got), 32'(pat(41, i)));
        end
        settle();
        check("R11 fwft marker not stored", 32'(ef_or), 32'd1);

        // R12: loaded offsets n=5, m=4, then defaults again
        do_reset(1'b0, 1'b1, 5'd5, 5'd4);
        for (int i = 0; i < 5; i++) write_word(pat(42, i));
        settle();
        check("R12 loaded n: at n", 32'(ae_n), 32'd0);
        write_word(pat(42, 5));
        settle();
        check("R12 loaded n: above n", 32'(ae_n), 32'd1);
        for (int i = 6; i < 11; i++) write_word(pat(42, i));
        settle();
        check("R12 loaded m: below D-m", 32'(af_n), 32'd1);
        write_word(pat(42, 11));
        settle();
        check("R12 loaded m: at D-m", 32'(af_n), 32'd0);
        do_reset(1'b0, 1'b0, 5'd5, 5'd4);
        for (int i = 0; i < 2; i++) write_word(pat(43, i));
        settle();
        check("R12 default n: at 2", 32'(ae_n), 32'd0);
        write_word(pat(43, 2));
        settle();
        check("R12 default n: above 2", 32'(ae_n), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule